// File: doc/BRIEF.md
# Remappable Peripheral Pin Crossbar

This block sits between a bank of general-purpose pins and a set of digital peripherals. It lets software choose which pin feeds each peripheral input and which peripheral output drives each pin. Inputs are chosen per peripheral: every peripheral input owns a 6-bit select field that names a pin. Outputs are chosen per pin: every pin owns a 6-bit code field that names the peripheral whose data and output enable reach that pin. Code 0 leaves the pin to the ordinary port logic, which is its latch value and its direction bit. Any combination of fields is legal, so one pin may feed several peripheral inputs and one peripheral output may drive several pins.

The mapping registers are protected by a lock flag. The flag changes only through a short state machine. The machine has three states. `LK_IDLE` moves to `LK_KEY1` on a control write of the first key word. `LK_KEY1` moves to `LK_ARMED` on a control write of the second key word. `LK_ARMED` returns to `LK_IDLE` on the next write of any kind. If that write goes to the control address, it sets or clears the flag. Any other write, or a wrong word, in `LK_KEY1` or `LK_ARMED` sends the machine back to `LK_IDLE`. Cycles without a write leave the state as it is. A one-way strap keeps the flag set once it has been set.

Every mapping field has a shadow copy that is written at the same time. The two copies are compared on every cycle. A difference raises a reset request, which stays high until the next reset.

Top module: `pps_crossbar`

## Requirements
- R1: Each peripheral input i has a 6-bit select field. A value below NPINS routes `pin_in[value]` to `per_in[i]`. Any value of NPINS or above, including the reset value 63 (all ones), holds `per_in[i]` at 0.
- R2: Each pin p has a 6-bit code field, which resets to 0. While the code is 0, `pad_out[p]` equals `port_lat[p]` and `pad_oe[p]` equals the inverse of `port_tris[p]`, where a tris value of 1 means input.
- R3: Some codes drive pin p from `per_out[code]` and `per_oe[code]`. These codes are 1 and 2 (comparators), 3 and 4 (UART1 transmit and request-to-send), 5 and 6 (UART2 transmit and request-to-send), 7 to 9 (SPI1 data, clock and select), 10 to 12 (the same three for SPI2) and 18 to 22 (output compare 1 to 5). Every other non-zero code, that is 13 to 17 and 23 to 63, drives `pad_out[p]` and `pad_oe[p]` to 0.
- R4: Register k at address 0+k holds input fields 2k and 2k+1. Register k at address 32+k holds pin fields 2k and 2k+1. In both banks the even field sits in bits 5:0 and the odd field in bits 13:8. Bits 7:6 and 15:14 read 0. The control register is at address 63. Its lock flag is bit 6 and every other bit reads 0.
- R5: Fields are independent. Several inputs may select the same pin, and several pins may carry the same code, with no lockout.
- R6: The lock flag resets to 0. While the flag is 1, writes to either mapping bank leave every field unchanged.
- R7: The flag changes only on a control write made while the machine is in `LK_ARMED`. That write copies `wr_data[6]` into the flag. Reaching `LK_ARMED` takes a control write of the full word 0x0046 and then a control write of 0x0057. Any other write between these steps aborts the sequence, and so does a wrong word.
- R8: While `one_way_en` is 1 and the flag is 1, an armed write that tries to clear the flag leaves it at 1. While `one_way_en` is 0, such a write clears the flag.
- R9: A mismatch between any mapping field and its shadow copy sets `cfg_mismatch_rst` on the next clock. It stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| one_way_en | input | 1 | Strap: once set, the lock flag cannot be cleared |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pin_in | input | NPINS | Levels received from the pins |
| port_lat | input | NPINS | Port latch values |
| port_tris | input | NPINS | Port direction bits (1 = input) |
| pad_out | output | NPINS | Data driven toward each pin |
| pad_oe | output | NPINS | Output enable for each pin |
| per_out | input | NCODE | Peripheral output data, indexed by code |
| per_oe | input | NCODE | Peripheral output enables, indexed by code |
| per_in | output | NIN | Routed peripheral inputs |
| cfg_mismatch_rst | output | 1 | Sticky configuration mismatch reset request |

## Verification
The bench uses the default values: NPINS = 16, NIN = 8 and NCODE = 23. With 16 pins, select values 16 to 62 fall outside the pin range, so the grounding rule for out-of-range selects can be tested as well as the all-ones reset value. With 23 codes, the gap codes 13 to 17 and the codes past 22 can both be swept, and the sweep confirms that they leave the pin quiet. With 8 inputs, the input bank is filled exactly, so reserved-bit masking can be seen on the last register.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int FIELD_W  = 6;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;
    localparam int IN_BASE  = 0;
    localparam int OUT_BASE = 32;
    localparam int CTRL_ADR = 63;
    localparam int LOCK_BIT = 6;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h0046;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'h0057;

    typedef logic [FIELD_W-1:0] sel_t;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_KEY1  = 2'd1,
        LK_ARMED = 2'd2
    } lk_state_e;

    // Codes that carry a peripheral output onto a pin
    function automatic logic code_assigned(input sel_t c);
        return ((c >= 6'd1)  && (c <= 6'd12)) ||
               ((c >= 6'd18) && (c <= 6'd22));
    endfunction

endpackage

// File: rtl/pps_lock_fsm.sv
module pps_lock_fsm
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              one_way_en,
    input  logic              wr_en,
    input  logic              is_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    output logic              lock_q,
    output logic              armed
);

    lk_state_e state_q, state_d;
    logic      lock_d;
    logic      wr_ctrl;

    assign wr_ctrl = wr_en && is_ctrl;
    assign armed   = (state_q == LK_ARMED);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // transitions: only writes move the machine
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                LK_IDLE:  state_d = (wr_ctrl && wr_data == KEY_FIRST)  ? LK_KEY1  : LK_IDLE;
                LK_KEY1:  state_d = (wr_ctrl && wr_data == KEY_SECOND) ? LK_ARMED : LK_IDLE;
                LK_ARMED: state_d = LK_IDLE;
                default:  state_d = LK_IDLE;
            endcase
        end
    end

    // outputs: lock flag update
    always_comb begin
        lock_d = lock_q;
        unique case (state_q)
            LK_ARMED: begin
                if (wr_ctrl) begin
                    if (wr_data[LOCK_BIT])           lock_d = 1'b1;
                    else if (!(one_way_en && lock_q)) lock_d = 1'b0;
                end
            end
            default: lock_d = lock_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

endmodule

// File: rtl/pps_cfg_regs.sv
module pps_cfg_regs
    import pps_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int NIN   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lock,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NIN-1:0][FIELD_W-1:0]   in_map,
    output logic [NPINS-1:0][FIELD_W-1:0] out_map,
    output logic                          mismatch
);

    localparam int IN_REGS  = (NIN + 1) / 2;
    localparam int OUT_REGS = (NPINS + 1) / 2;

    logic [NIN-1:0][FIELD_W-1:0]   in_map_q,  in_shd_q;
    logic [NPINS-1:0][FIELD_W-1:0] out_map_q, out_shd_q;
    logic                          mismatch_q;

    logic [2*IN_REGS-1:0][FIELD_W-1:0]  in_pad;
    logic [2*OUT_REGS-1:0][FIELD_W-1:0] out_pad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_map_q  <= '1;
            in_shd_q  <= '1;
            out_map_q <= '0;
            out_shd_q <= '0;
        end else if (wr_en && !lock) begin
            for (int i = 0; i < NIN; i++) begin
                if (wr_addr == ADDR_W'(IN_BASE + i / 2)) begin
                    in_map_q[i] <= (i % 2 == 1) ? wr_data[13:8] : wr_data[5:0];
                    in_shd_q[i] <= (i % 2 == 1) ? wr_data[13:8] : wr_data[5:0];
                end
            end
            for (int p = 0; p < NPINS; p++) begin
                if (wr_addr == ADDR_W'(OUT_BASE + p / 2)) begin
                    out_map_q[p] <= (p % 2 == 1) ? wr_data[13:8] : wr_data[5:0];
                    out_shd_q[p] <= (p % 2 == 1) ? wr_data[13:8] : wr_data[5:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mismatch_q <= 1'b0;
        else        mismatch_q <= mismatch_q
                                | (in_map_q  != in_shd_q)
                                | (out_map_q != out_shd_q);
    end

    assign in_pad  = (2*IN_REGS*FIELD_W)'(in_map_q);
    assign out_pad = (2*OUT_REGS*FIELD_W)'(out_map_q);

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < IN_REGS; k++) begin
            if (rd_addr == ADDR_W'(IN_BASE + k))
                rd_data = {2'b00, in_pad[2*k+1], 2'b00, in_pad[2*k]};
        end
        for (int k = 0; k < OUT_REGS; k++) begin
            if (rd_addr == ADDR_W'(OUT_BASE + k))
                rd_data = {2'b00, out_pad[2*k+1], 2'b00, out_pad[2*k]};
        end
        if (rd_addr == ADDR_W'(CTRL_ADR))
            rd_data[LOCK_BIT] = lock;
    end

    assign in_map   = in_map_q;
    assign out_map  = out_map_q;
    assign mismatch = mismatch_q;

endmodule

// File: rtl/pps_in_route.sv
module pps_in_route
    import pps_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int NIN   = 8
) (
    input  logic [NIN-1:0][FIELD_W-1:0] in_map,
    input  logic [NPINS-1:0]            pin_in,
    output logic [NIN-1:0]              per_in
);

    localparam int PIN_W = $clog2(NPINS);

    for (genvar i = 0; i < NIN; i++) begin : g_in
        logic in_range;
        assign in_range  = ({1'b0, in_map[i]} < (FIELD_W+1)'(NPINS));
        assign per_in[i] = in_range ? pin_in[in_map[i][PIN_W-1:0]] : 1'b0;
    end

endmodule

// File: rtl/pps_out_route.sv
module pps_out_route
    import pps_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int NCODE = 23
) (
    input  logic [NPINS-1:0][FIELD_W-1:0] out_map,
    input  logic [NPINS-1:0]              port_lat,
    input  logic [NPINS-1:0]              port_tris,
    input  logic [NCODE-1:0]              per_out,
    input  logic [NCODE-1:0]              per_oe,
    output logic [NPINS-1:0]              pad_out,
    output logic [NPINS-1:0]              pad_oe
);

    localparam int CODE_W = $clog2(NCODE);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        sel_t code;
        logic routed;
        logic o_bit, oe_bit;

        assign code   = out_map[p];
        assign routed = code_assigned(code) && ({1'b0, code} < (FIELD_W+1)'(NCODE));

        always_comb begin
            if (code == '0) begin
                o_bit  = port_lat[p];
                oe_bit = ~port_tris[p];
            end else if (routed) begin
                o_bit  = per_out[code[CODE_W-1:0]];
                oe_bit = per_oe[code[CODE_W-1:0]];
            end else begin
                o_bit  = 1'b0;
                oe_bit = 1'b0;
            end
        end

        assign pad_out[p] = o_bit;
        assign pad_oe[p]  = oe_bit;
    end

endmodule

// File: rtl/pps_crossbar.sv
module pps_crossbar
    import pps_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int NIN   = 8,
    parameter int NCODE = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              one_way_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  port_lat,
    input  logic [NPINS-1:0]  port_tris,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NCODE-1:0]  per_out,
    input  logic [NCODE-1:0]  per_oe,
    output logic [NIN-1:0]    per_in,
    output logic              cfg_mismatch_rst
);

    logic                          is_ctrl;
    logic                          lock_q;
    logic                          lock_armed;
    logic [NIN-1:0][FIELD_W-1:0]   in_map;
    logic [NPINS-1:0][FIELD_W-1:0] out_map;

    assign is_ctrl = (wr_addr == ADDR_W'(CTRL_ADR));

    pps_lock_fsm u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .one_way_en (one_way_en),
        .wr_en      (wr_en),
        .is_ctrl    (is_ctrl),
        .wr_data    (wr_data),
        .lock_q     (lock_q),
        .armed      (lock_armed)
    );

    pps_cfg_regs #(.NPINS(NPINS), .NIN(NIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (lock_q),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .in_map   (in_map),
        .out_map  (out_map),
        .mismatch (cfg_mismatch_rst)
    );

    pps_in_route #(.NPINS(NPINS), .NIN(NIN)) u_in (
        .in_map (in_map),
        .pin_in (pin_in),
        .per_in (per_in)
    );

    pps_out_route #(.NPINS(NPINS), .NCODE(NCODE)) u_out (
        .out_map   (out_map),
        .port_lat  (port_lat),
        .port_tris (port_tris),
        .per_out   (per_out),
        .per_oe    (per_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

endmodule

// File: rtl/pps_crossbar_chk.sv
module pps_crossbar_chk
    import pps_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int NIN   = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          one_way_en,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic                          lock_q,
    input logic                          armed,
    input logic [NIN-1:0][FIELD_W-1:0]   in_map,
    input logic [NPINS-1:0][FIELD_W-1:0] out_map,
    input logic [NIN-1:0]                per_in,
    input logic [NPINS-1:0]              port_lat,
    input logic [NPINS-1:0]              port_tris,
    input logic [NPINS-1:0]              pad_out,
    input logic [NPINS-1:0]              pad_oe,
    input logic                          cfg_mismatch_rst
);

    // R6: mapping frozen while locked
    a_r6_locked_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(in_map) && $stable(out_map)));

    // R7: flag moves only on an armed control write
    a_r7_lock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && wr_en && wr_addr == ADDR_W'(CTRL_ADR)) |=> $stable(lock_q));

    // R8: one-way strap keeps the flag set
    a_r8_one_way_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (one_way_en && lock_q) |=> lock_q);

    // R9: mismatch request is sticky
    a_r9_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mismatch_rst |=> cfg_mismatch_rst);

    for (genvar i = 0; i < NIN; i++) begin : g_r1
        // R1: out-of-range select grounds the input
        a_r1_bad_select_low: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, in_map[i]} >= (FIELD_W+1)'(NPINS)) |-> !per_in[i]);
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_r2
        // R2: code 0 hands the pin to the port
        a_r2_null_is_port: assert property (@(posedge clk) disable iff (!rst_n)
            (out_map[p] == '0) |-> (pad_out[p] == port_lat[p] && pad_oe[p] == !port_tris[p]));
    end

endmodule

bind pps_crossbar pps_crossbar_chk #(.NPINS(NPINS), .NIN(NIN)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .one_way_en       (one_way_en),
    .wr_en            (wr_en),
    .wr_addr          (wr_addr),
    .lock_q           (lock_q),
    .armed            (lock_armed),
    .in_map           (in_map),
    .out_map          (out_map),
    .per_in           (per_in),
    .port_lat         (port_lat),
    .port_tris        (port_tris),
    .pad_out          (pad_out),
    .pad_oe           (pad_oe),
    .cfg_mismatch_rst (cfg_mismatch_rst)
);

// File: tb/tb_pps_crossbar.sv
`timescale 1ns/1ps
module tb_pps_crossbar;

    localparam int NPINS = 16;
    localparam int NIN   = 8;
    localparam int NCODE = 23;

    logic             clk = 1'b0;
    logic             rst_n, one_way_en, wr_en;
    logic [5:0]       wr_addr, rd_addr;
    logic [15:0]      wr_data, rd_data;
    logic [NPINS-1:0] pin_in, port_lat, port_tris, pad_out, pad_oe;
    logic [NCODE-1:0] per_out, per_oe;
    logic [NIN-1:0]   per_in;
    logic             cfg_mismatch_rst;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pps_crossbar #(.NPINS(NPINS), .NIN(NIN), .NCODE(NCODE)) dut (
        .clk(clk), .rst_n(rst_n), .one_way_en(one_way_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .port_lat(port_lat), .port_tris(port_tris),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
        .cfg_mismatch_rst(cfg_mismatch_rst)
    );

    function automatic bit exp_assigned(input int c);
        return (c >= 1 && c <= 12) || (c >= 18 && c <= 22);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic key_then(input logic [15:0] d);
        wr(6'd63, 16'h0046);
        wr(6'd63, 16'h0057);
        wr(6'd63, d);
    endtask

    task automatic do_reset(input logic ow);
        @(negedge clk);
        rst_n = 1'b0; one_way_en = ow; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        pin_in = '1; port_lat = 16'hA5C3; port_tris = 16'h0F0F;
        #1;
        chk("R1 reset selects ground inputs", 32'(per_in), 32'h0);
        chk("R2 reset pad_out follows latch", 32'(pad_out), 32'hA5C3);
        chk("R2 reset pad_oe from tris", 32'(pad_oe), 32'hF0F0);
        rd_chk("R4 reset input reg", 6'd0, 16'h3F3F);
        rd_chk("R4 reset pin reg", 6'd32, 16'h0000);
        rd_chk("R6 reset unlocked", 6'd63, 16'h0000);
        chk("R9 reset no mismatch", 32'(cfg_mismatch_rst), 32'h0);
    endtask

    task automatic t_input;
        wr(6'd0, 16'h0502);
        pin_in = 16'h0020; #1;
        chk("R1 in0 from pin2 low", 32'(per_in[0]), 32'h0);
        chk("R1 in1 from pin5 high", 32'(per_in[1]), 32'h1);
        pin_in = 16'h0004; #1;
        chk("R1 in0 from pin2 high", 32'(per_in[0]), 32'h1);
        chk("R1 in1 from pin5 low", 32'(per_in[1]), 32'h0);
        wr(6'd1, 16'h0210);
        pin_in = '1; #1;
        chk("R1 out of range select 16", 32'(per_in[2]), 32'h0);
        chk("R5 two inputs share pin2", 32'({per_in[3], per_in[0]}), 32'h3);
        pin_in = ~16'h0004; #1;
        chk("R5 shared pin2 low", 32'({per_in[3], per_in[0]}), 32'h0);
        wr(6'd2, 16'h0F00);
        pin_in = 16'h8000; #1;
        chk("R1 in5 from pin15 in4 from pin0", 32'(per_in[5:4]), 32'h2);
        wr(6'd3, 16'hFFFF);
        rd_chk("R4 reserved bits read zero", 6'd3, 16'h3F3F);
        pin_in = '1; #1;
        chk("R1 all-ones select grounds", 32'(per_in[7:6]), 32'h0);
        rd_chk("R4 input reg readback", 6'd0, 16'h0502);
    endtask

    task automatic t_output;
        port_lat = '1; port_tris = '0; per_out = '0; per_oe = '0;
        wr(6'd32, 16'h0312);
        per_out = NCODE'(1) << 18; per_oe = NCODE'(1) << 3; #1;
        chk("R3 pin0 code18 pin1 code3 data", 32'(pad_out[1:0]), 32'h1);
        chk("R3 pin0 code18 pin1 code3 oe", 32'(pad_oe[1:0]), 32'h2);
        wr(6'd33, 16'h280D);
        per_out = '1; per_oe = '1; #1;
        chk("R3 codes 13 and 40 quiet data", 32'(pad_out[3:2]), 32'h0);
        chk("R3 codes 13 and 40 quiet oe", 32'(pad_oe[3:2]), 32'h0);
        wr(6'd34, 16'h0707);
        per_out = NCODE'(1) << 7; #1;
        chk("R5 code7 on two pins high", 32'(pad_out[5:4]), 32'h3);
        per_out = '0; #1;
        chk("R5 code7 on two pins low", 32'(pad_out[5:4]), 32'h0);
        chk("R2 untouched pins follow port", 32'({pad_oe[15:6], pad_out[15:6]}), 32'hFFFFF);
        rd_chk("R4 pin reg readback", 6'd32, 16'h0312);
        for (int c = 1; c < 32; c++) begin
            wr(6'd32, {8'h03, 2'b00, 6'(c)});
            per_out = NCODE'(1) << c; per_oe = NCODE'(1) << c; #1;
            chk($sformatf("R3 sweep code %0d data", c), 32'(pad_out[0]), 32'(exp_assigned(c)));
            chk($sformatf("R3 sweep code %0d oe", c), 32'(pad_oe[0]), 32'(exp_assigned(c)));
        end
        wr(6'd32, 16'h0300);
        port_lat[0] = 1'b0; port_tris[0] = 1'b1; #1;
        chk("R2 code0 returns pin to port input", 32'({pad_oe[0], pad_out[0]}), 32'h0);
        port_lat[0] = 1'b1; port_tris[0] = 1'b0; #1;
        chk("R2 code0 returns pin to port output", 32'({pad_oe[0], pad_out[0]}), 32'h3);
    endtask

    task automatic t_lock_one_way;
        key_then(16'h0040);
        rd_chk("R7 key sets lock", 6'd63, 16'h0040);
        wr(6'd0, 16'h0101);
        rd_chk("R6 locked input reg unchanged", 6'd0, 16'h0502);
        wr(6'd32, 16'h0505);
        rd_chk("R6 locked pin reg unchanged", 6'd32, 16'h0300);
        pin_in = 16'h0004; #1;
        chk("R6 locked routing unchanged", 32'(per_in[0]), 32'h1);
        key_then(16'h0000);
        rd_chk("R8 one-way keeps lock", 6'd63, 16'h0040);
    endtask

    task automatic t_key_abort;
        do_reset(1'b0);
        wr(6'd63, 16'h0046);
        wr(6'd0, 16'h0001);
        wr(6'd63, 16'h0057);
        wr(6'd63, 16'h0040);
        rd_chk("R7 write between keys aborts", 6'd63, 16'h0000);
        rd_chk("R7 interrupting write still lands", 6'd0, 16'h0001);
        wr(6'd63, 16'h0046);
        wr(6'd63, 16'h0057);
        wr(6'd5, 16'h1234);
        wr(6'd63, 16'h0040);
        rd_chk("R7 write after keys aborts", 6'd63, 16'h0000);
        wr(6'd63, 16'h0146);
        wr(6'd63, 16'h0057);
        wr(6'd63, 16'h0040);
        rd_chk("R7 wrong upper byte rejected", 6'd63, 16'h0000);
        key_then(16'h0040);
        rd_chk("R7 key sets lock strap off", 6'd63, 16'h0040);
        key_then(16'h0000);
        rd_chk("R8 strap off allows clear", 6'd63, 16'h0000);
        wr(6'd0, 16'h0203);
        rd_chk("R6 unlocked write lands", 6'd0, 16'h0203);
    endtask

    task automatic t_mismatch;
        do_reset(1'b1);
        chk("R9 clean after reset", 32'(cfg_mismatch_rst), 32'h0);
        @(negedge clk);
        force dut.u_regs.in_map_q = '0;
        @(negedge clk);
        release dut.u_regs.in_map_q;
        #1;
        chk("R9 upset raises request", 32'(cfg_mismatch_rst), 32'h1);
        for (int k = 0; k < 4; k++) wr(6'(k), 16'h3F3F);
        chk("R9 request sticky after repair", 32'(cfg_mismatch_rst), 32'h1);
        do_reset(1'b1);
        chk("R9 reset clears request", 32'(cfg_mismatch_rst), 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; one_way_en = 1'b1; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        pin_in = '0; port_lat = '0; port_tris = '1;
        per_out = '0; per_oe = '0;
        t_reset();
        t_input();
        t_output();
        t_lock_one_way();
        t_key_abort();
        t_mismatch();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule